// File: doc/BRIEF.md
# Two-Pass Halfword Execute Unit

This block carries out the 32-bit integer register-register and register-immediate operations (add, subtract, bitwise logic, set-less-than and the three shifts) with a single 16-bit adder/logic unit. Each operation is worked in two passes: a low-halfword pass and a high-halfword pass. The carry out of the low pass is held in a flag and fed into the high pass, so the two halves form one 32-bit result.

The register file lives outside the block. It is 16 bits wide and has one synchronous read address per cycle: read data appears one cycle after the address. It also has a write port. A halfword is addressed as `{register index, half}`, where half 0 is bits 15:0. A front end offers an operation with `start` whenever `ready` is high. The block then reads its operands halfword by halfword, writes the result halves back, and pulses `done` in its final cycle. A new operation may be accepted in that same final cycle, so back-to-back operations need no idle gap. `rst_n` is asynchronous, active low, and must be released synchronously to `clk`.

Top module: `half_chain_exec`

## Requirements
- R1: Operation codes 0 (add) and 1 (subtract) give the full 32-bit wrap-around sum or difference. The carry or borrow passes correctly from bit 15 into bit 16.
- R2: Operation codes 2 (and), 3 (or) and 4 (xor) give the bitwise 32-bit result.
- R3: Codes 0 to 4 run in exactly four cycles after acceptance. The low result half is written in the second cycle, the high half in the fourth cycle, and `done` is high in the fourth cycle.
- R4: Codes 5 (signed less-than) and 6 (unsigned less-than) write 1 or 0 to the low half and 0 to the high half. They take six cycles, and the high half is written together with `done`.
- R5: Codes 7 (shift left), 8 (logical right) and 9 (arithmetic right) move the 32-bit operand by the amount in bits 4:0 of the second operand. Bits pass across the halfword boundary. These operations take 6 + amount cycles.
- R6: Reading register 0 yields zero in both halves, whatever the register file returns for addresses 0 and 1.
- R7: An operation whose destination is register 0 produces no write strobe at all.
- R8: With `use_imm` high, the 32-bit `imm` replaces the second register operand, for both halves and for the shift amount.
- R9: `start` is ignored while `ready` is low, and operand inputs are sampled only at acceptance. After reset `ready` is high and `done` and `rf_we` are low.
- R10: A halfword address is `{index, half}`, with the half bit as LSB. An operation accepted in the final cycle of its predecessor reads the predecessor's result correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer an operation; taken when `ready` is high |
| op | input | 4 | Operation code (0..9) |
| use_imm | input | 1 | Use `imm` as the second operand |
| rs1 | input | 5 | First source register index |
| rs2 | input | 5 | Second source register index |
| rd | input | 5 | Destination register index |
| imm | input | 32 | Immediate operand |
| ready | output | 1 | Block can accept an operation this cycle |
| done | output | 1 | Final cycle of the current operation |
| rf_raddr | output | 6 | Register file read halfword address |
| rf_rdata | input | 16 | Register file read data, one cycle after the address |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 6 | Register file write halfword address |
| rf_wdata | output | 16 | Register file write data |

## Verification
The final cycle of one operation does two jobs at once. It writes the high result half and it accepts the next operation, issuing that operation's first low-half read. The bench provokes this by issuing every operation in the same cycle that `done` of the previous one appears. It also chains operations whose sources are the register just written. A scoreboard of expected halfword writes, computed from a 32-bit reference model, judges both the written values and their addresses, and each operation's cycle count is compared with the count its class requires.

// File: rtl/hx_pkg.sv
package hx_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_R2L,
    ST_OPL,
    ST_R2H,
    ST_OPH,
    ST_SHF,
    ST_WRL,
    ST_WRH
  } st_e;

  function automatic logic is_cmp(op_e o);
    return (o == OP_SLT) || (o == OP_SLTU);
  endfunction

  function automatic logic is_shift(op_e o);
    return (o == OP_SLL) || (o == OP_SRL) || (o == OP_SRA);
  endfunction

  function automatic logic is_plain(op_e o);
    return !is_cmp(o) && !is_shift(o);
  endfunction

  function automatic logic uses_sub(op_e o);
    return (o == OP_SUB) || is_cmp(o);
  endfunction

endpackage

// File: rtl/hx_alu16.sv
module hx_alu16
  import hx_pkg::*;
#(
  parameter int HW = 16
) (
  input  op_e           fn,
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  input  logic          cin,
  output logic [HW-1:0] y,
  output logic          co
);

  logic [HW:0]   sum;
  logic [HW-1:0] b_eff;

  always_comb begin
    b_eff = uses_sub(fn) ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{HW{1'b0}}, cin};
    co    = sum[HW];
    unique case (fn)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = sum[HW-1:0];
    endcase
  end

endmodule

// File: rtl/hx_opnd.sv
module hx_opnd #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [HW-1:0] d,
  input  logic          sh_en,
  input  logic          sh_left,
  input  logic          sh_arith,
  output logic [HW-1:0] lo,
  output logic [HW-1:0] hi
);

  logic [HW-1:0] lo_n, hi_n;

  always_comb begin
    lo_n = lo;
    hi_n = hi;
    if (ld_lo) lo_n = d;
    if (ld_hi) hi_n = d;
    if (sh_en) begin
      if (sh_left) begin
        hi_n = {hi[HW-2:0], lo[HW-1]};
        lo_n = {lo[HW-2:0], 1'b0};
      end else begin
        hi_n = {sh_arith & hi[HW-1], hi[HW-1:1]};
        lo_n = {hi[0], lo[HW-1:1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    lo <= lo_n;
    hi <= hi_n;
  end

endmodule

// File: rtl/hx_ctrl.sv
module hx_ctrl
  import hx_pkg::*;
#(
  parameter int HW  = 16,
  parameter int RIW = 5,
  parameter int SAW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  op_e             op_i,
  input  logic            use_imm_i,
  input  logic [RIW-1:0]  rs1_i,
  input  logic [RIW-1:0]  rs2_i,
  input  logic [RIW-1:0]  rd_i,
  input  logic [2*HW-1:0] imm_i,
  input  logic [SAW-1:0]  shamt_i,
  output st_e             st,
  output op_e             op_q,
  output logic            uimm_q,
  output logic [RIW-1:0]  rs1_q,
  output logic [RIW-1:0]  rs2_q,
  output logic [RIW-1:0]  rd_q,
  output logic [2*HW-1:0] imm_q,
  output logic            ready,
  output logic            done
);

  st_e            st_n;
  logic [SAW-1:0] cnt, cnt_n;
  logic           accept;

  always_comb begin
    done   = ((st == ST_OPH) && is_plain(op_q)) || (st == ST_WRH);
    ready  = (st == ST_IDLE) || done;
    accept = ready && start;
    st_n   = st;
    cnt_n  = cnt;
    if (ready) begin
      st_n = accept ? ST_R2L : ST_IDLE;
    end else begin
      unique case (st)
        ST_R2L: st_n = ST_OPL;
        ST_OPL: begin
          st_n  = ST_R2H;
          cnt_n = shamt_i;
        end
        ST_R2H: st_n = ST_OPH;
        ST_OPH: begin
          if (is_shift(op_q) && (cnt != '0)) st_n = ST_SHF;
          else                               st_n = ST_WRL;
        end
        ST_SHF: begin
          cnt_n = cnt - 1'b1;
          if (cnt == SAW'(1)) st_n = ST_WRL;
        end
        ST_WRL:  st_n = ST_WRH;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      op_q   <= op_i;
      uimm_q <= use_imm_i;
      rs1_q  <= rs1_i;
      rs2_q  <= rs2_i;
      rd_q   <= rd_i;
      imm_q  <= imm_i;
    end
  end

  // R9: an accepted operation makes the block busy on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R5: the shift state is only ever entered with work left to do
  a_r5_shift_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHF) |-> (cnt != '0));

endmodule

// File: rtl/half_chain_exec.sv
module half_chain_exec
  import hx_pkg::*;
#(
  parameter int HW  = 16,
  parameter int RIW = 5,
  parameter int SAW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic            use_imm,
  input  logic [RIW-1:0]  rs1,
  input  logic [RIW-1:0]  rs2,
  input  logic [RIW-1:0]  rd,
  input  logic [2*HW-1:0] imm,
  output logic            ready,
  output logic            done,
  output logic [RIW:0]    rf_raddr,
  input  logic [HW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [RIW:0]    rf_waddr,
  output logic [HW-1:0]   rf_wdata
);

  localparam int WW = 2 * HW;

  st_e             st;
  op_e             op_q;
  logic            uimm_q;
  logic [RIW-1:0]  rs1_q, rs2_q, rd_q;
  logic [WW-1:0]   imm_q;
  logic [HW-1:0]   rdv, a_op, b_op, alu_y, a_lo, a_hi, wd;
  logic            alu_co, cy_q, lt_q, lt_n, rz_q, hi_ph, cin, wr, half;

  hx_ctrl #(.HW(HW), .RIW(RIW), .SAW(SAW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_i      (op_e'(op)),
    .use_imm_i (use_imm),
    .rs1_i     (rs1),
    .rs2_i     (rs2),
    .rd_i      (rd),
    .imm_i     (imm),
    .shamt_i   (b_op[SAW-1:0]),
    .st        (st),
    .op_q      (op_q),
    .uimm_q    (uimm_q),
    .rs1_q     (rs1_q),
    .rs2_q     (rs2_q),
    .rd_q      (rd_q),
    .imm_q     (imm_q),
    .ready     (ready),
    .done      (done)
  );

  // Read address for the next cycle; register 0 reads are masked on return.
  always_comb begin
    if (ready) begin
      rf_raddr = {rs1, 1'b0};
    end else begin
      unique case (st)
        ST_R2L:  rf_raddr = {rs2_q, 1'b0};
        ST_OPL:  rf_raddr = {rs1_q, 1'b1};
        ST_R2H:  rf_raddr = {rs2_q, 1'b1};
        default: rf_raddr = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rz_q <= 1'b1;
    else        rz_q <= (rf_raddr[RIW:1] == '0);
  end

  assign rdv   = rz_q ? '0 : rf_rdata;
  assign hi_ph = (st == ST_OPH);
  assign b_op  = uimm_q ? (hi_ph ? imm_q[WW-1:HW] : imm_q[HW-1:0]) : rdv;
  assign a_op  = hi_ph ? a_hi : a_lo;
  assign cin   = hi_ph ? cy_q : uses_sub(op_q);

  hx_alu16 #(.HW(HW)) u_alu (
    .fn  (op_q),
    .a   (a_op),
    .b   (b_op),
    .cin (cin),
    .y   (alu_y),
    .co  (alu_co)
  );

  hx_opnd #(.HW(HW)) u_opnd (
    .clk      (clk),
    .ld_lo    (st == ST_R2L),
    .ld_hi    (st == ST_R2H),
    .d        (rdv),
    .sh_en    (st == ST_SHF),
    .sh_left  (op_q == OP_SLL),
    .sh_arith (op_q == OP_SRA),
    .lo       (a_lo),
    .hi       (a_hi)
  );

  // Less-than from the high pass: unsigned uses the borrow, signed the signs.
  assign lt_n = (op_q == OP_SLTU) ? !alu_co
              : ((a_hi[HW-1] != b_op[HW-1]) ? a_hi[HW-1] : alu_y[HW-1]);

  always_ff @(posedge clk) begin
    if (st == ST_OPL) cy_q <= alu_co;
    if (st == ST_OPH) lt_q <= lt_n;
  end

  always_comb begin
    wr   = 1'b0;
    half = 1'b0;
    wd   = '0;
    if (is_plain(op_q)) begin
      if (st == ST_OPL) begin
        wr = 1'b1;
        wd = alu_y;
      end else if (st == ST_OPH) begin
        wr   = 1'b1;
        half = 1'b1;
        wd   = alu_y;
      end
    end else if (st == ST_WRL) begin
      wr = 1'b1;
      wd = is_cmp(op_q) ? {{(HW-1){1'b0}}, lt_q} : a_lo;
    end else if (st == ST_WRH) begin
      wr   = 1'b1;
      half = 1'b1;
      wd   = is_cmp(op_q) ? '0 : a_hi;
    end
  end

  assign rf_we    = wr && (rd_q != '0);
  assign rf_waddr = {rd_q, half};
  assign rf_wdata = wd;

  // R7: register 0 is never written
  a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr[RIW:1] != '0));

  // R3: plain operations finish exactly four cycles after acceptance
  a_r3_plain_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready && (op < 4'd5)) |-> ##4 done);

  // R3/R4: the high half is always the last write, paired with done
  a_r4_high_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr[0]) |-> done);

  // R4: compare results carry nothing in the upper half
  a_r4_cmp_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_waddr[0] && is_cmp(op_q)) |-> (rf_wdata == '0));

endmodule

// File: tb/tb_half_chain_exec.sv
module tb_half_chain_exec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic        use_imm;
  logic [4:0]  rs1, rs2, rd;
  logic [31:0] imm;
  logic        ready, done;
  logic [5:0]  rf_raddr, rf_waddr;
  logic [15:0] rf_rdata, rf_wdata;
  logic        rf_we;

  always #4 clk = ~clk;

  half_chain_exec dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_imm(use_imm),
    .rs1(rs1), .rs2(rs2), .rd(rd), .imm(imm), .ready(ready), .done(done),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // Register file model: synchronous read, read-before-write.
  logic [15:0] mem [64];
  always @(posedge clk) begin
    if (rf_we) mem[rf_waddr] <= rf_wdata;
    rf_rdata <= mem[rf_raddr];
  end

  typedef struct {
    logic [5:0]  a;
    logic [15:0] d;
    string       tag;
  } exp_t;

  exp_t        sb [$];
  logic [31:0] ref_r [32];
  int          nchk  = 0;
  int          nfail = 0;
  bit          ended = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_op(input int o, input logic [31:0] a,
                                         input logic [31:0] b);
    case (o)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      6: return (a < b) ? 32'd1 : 32'd0;
      7: return a << b[4:0];
      8: return a >> b[4:0];
      default: return $signed(a) >>> b[4:0];
    endcase
  endfunction

  function automatic int ref_len(input int o, input logic [31:0] b);
    if (o <= 4) return 4;
    if (o <= 6) return 6;
    return 6 + int'(b[4:0]);
  endfunction

  // Monitor: every write strobe must match the next expected halfword.
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "unexpected write", {10'd0, rf_waddr, rf_wdata}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk((rf_waddr == e.a) && (rf_wdata == e.d), e.tag, "write addr/data (R10)",
            {10'd0, rf_waddr, rf_wdata}, {10'd0, e.a, e.d});
      end
    end
  end

  task automatic run(input int o, input int s1, input int s2, input int d,
                     input bit ui, input logic [31:0] im, input bit junk,
                     input string tag);
    logic [31:0] a, b, res;
    int k, el;
    a   = ref_r[s1];
    b   = ui ? im : ref_r[s2];
    res = ref_op(o, a, b);
    el  = ref_len(o, b);
    if (d != 0) begin
      sb.push_back('{a: {d[4:0], 1'b0}, d: res[15:0],  tag: tag});
      sb.push_back('{a: {d[4:0], 1'b1}, d: res[31:16], tag: tag});
      ref_r[d] = res;
    end
    while (!ready) @(negedge clk);
    op      = o[3:0];
    rs1     = s1[4:0];
    rs2     = s2[4:0];
    rd      = d[4:0];
    use_imm = ui;
    imm     = im;
    start   = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start = 1'b0;
      if (junk && k == 2) begin
        // R9: offer a different operation while busy; it must be ignored
        start = 1'b1;
        op    = 4'd1;
        rd    = 5'd9;
        rs1   = 5'd4;
        imm   = 32'hFFFF_FFFF;
      end
    end while (!done && k < 300);
    chk(k == el, tag, "cycle count", k, el);
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) ref_r[i] = i * 32'h0101_0101;
    ref_r[1] = 32'h0000_FFFF;
    ref_r[2] = 32'h0000_0001;
    ref_r[3] = 32'h0001_0000;
    ref_r[4] = 32'hFFFF_FFFF;
    ref_r[5] = 32'h8000_0000;
    ref_r[6] = 32'h0001_FFFF;
    ref_r[8] = 32'h1234_5678;
    ref_r[9] = 32'h0F0F_00FF;
    for (int i = 0; i < 32; i++) begin
      mem[2*i]   = ref_r[i][15:0];
      mem[2*i+1] = ref_r[i][31:16];
    end
    ref_r[0] = 32'd0;
    mem[0]   = 16'hDEAD;
    mem[1]   = 16'hBEEF;

    rst_n = 1'b0; start = 1'b0; op = '0; use_imm = 1'b0;
    rs1 = '0; rs2 = '0; rd = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R9", "ready after reset", ready, 1);
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    chk(rf_we == 1'b0, "R9", "rf_we after reset", rf_we, 0);

    run(0, 1, 2, 10, 0, 0, 0, "R1");   // carry into bit 16
    run(1, 3, 2, 11, 0, 0, 0, "R1");   // borrow out of bit 16
    run(0, 4, 2, 12, 0, 0, 0, "R1");   // full wrap
    run(1, 2, 4, 13, 0, 0, 0, "R1");
    run(2, 8, 9, 14, 0, 0, 0, "R2");
    run(3, 8, 9, 15, 0, 0, 0, "R2");
    run(4, 8, 9, 16, 0, 0, 0, "R2");
    run(5, 4, 2, 17, 0, 0, 0, "R4");   // -1 < 1 signed
    run(6, 4, 2, 18, 0, 0, 0, "R4");   // not below unsigned
    run(5, 3, 6, 19, 0, 0, 0, "R4");   // equal highs, borrow from low
    run(6, 6, 3, 20, 0, 0, 0, "R4");
    run(5, 5, 2, 21, 0, 0, 0, "R4");   // most negative value
    run(7, 8, 0, 22, 1, 32'd0,  0, "R5");
    run(7, 1, 0, 23, 1, 32'd17, 0, "R5");
    run(8, 3, 0, 24, 1, 32'd1,  0, "R5");
    run(9, 5, 0, 25, 1, 32'd31, 0, "R5");
    run(8, 5, 2, 26, 0, 0,      0, "R5");
    run(7, 1, 2, 26, 0, 0,      0, "R5");
    run(0, 8, 0, 27, 1, 32'hFFFF_FFFF, 0, "R8");
    run(4, 8, 0, 28, 1, 32'hFFFF_0000, 0, "R8");
    run(9, 4, 0, 28, 1, 32'hFFFF_FFE4, 0, "R8");
    run(0, 0, 0, 29, 0, 0, 0, "R6");
    run(0, 0, 8, 30, 0, 0, 0, "R6");
    run(3, 8, 0, 31, 0, 0, 0, "R6");
    run(0, 8, 9, 0,  0, 0, 0, "R7");
    run(3, 0, 0, 7,  0, 0, 0, "R7");
    run(0, 1, 2, 6,  0, 0, 1, "R9");
    run(7, 8, 0, 6,  1, 32'd3, 1, "R9");
    run(0, 10, 10, 11, 0, 0, 0, "R10");
    run(1, 11, 10, 11, 0, 0, 0, "R10");
    run(6, 11, 11, 12, 0, 0, 0, "R10");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7", "writes outstanding", sb.size(), 0);
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule